// File: doc/BRIEF.md
# Right-Hand Wall-Following Maze Robot Controller

This block is a clocked Moore state machine that guides a small walking robot out of a maze. The strategy is to keep the right-hand feeler in contact with a wall. Two contact inputs report whether the left and the right feeler touch something. Three actuator outputs command a forward step, a small turn to the left and a small turn to the right. A turn and a forward step may be requested in the same cycle.

The controller moves through five behaviours:

- **Seek:** walk straight until something is hit.
- **Pivot:** rotate left until neither feeler touches.
- **Drift right:** step while veering right, looking for the wall.
- **Drift left:** step while veering left, backing off the wall.
- **Round:** step while veering right, swinging around an outside corner.

Any left-feeler contact during wall following sends the machine back to pivot. The current state code is brought out so that the position in the strategy can be observed.

The feelers are sampled on the rising clock edge and are assumed to be synchronized already. Reset is synchronous and active high.

Top module: `maze_follower`

## Requirements
- R1: While `rst` is 1 at a rising edge, the next cycle shows `state_code` = 0 (seek) with only `step_fwd` active.
- R2: In seek (code 0) the state stays at 0 while both feelers are 0, and goes to pivot (code 1) when either feeler is 1.
- R3: In pivot (code 1) the state stays at 1 while either feeler is 1, and goes to drift-right (code 2) when both feelers are 0.
- R4: In drift-right (code 2) with `feel_l` = 0, the state stays at 2 when `feel_r` = 0, and goes to drift-left (code 3) when `feel_r` = 1.
- R5: In drift-left (code 3) with `feel_l` = 0, the state stays at 3 when `feel_r` = 1, and goes to round (code 4) when `feel_r` = 0.
- R6: In round (code 4) with `feel_l` = 0, the state stays at 4 when `feel_r` = 0, and goes to drift-left (code 3) when `feel_r` = 1.
- R7: In codes 2, 3 and 4, `feel_l` = 1 sends the state to pivot (code 1) whatever `feel_r` is. This takes priority over every right-feeler arc.
- R8: The outputs depend only on `state_code`. As {`step_fwd`, `turn_left`, `turn_right`} they are:

  | Code | State | Outputs |
  |------|-------|---------|
  | 0 | seek | 100 |
  | 1 | pivot | 010 |
  | 2 | drift-right | 101 |
  | 3 | drift-left | 110 |
  | 4 | round | 101 |

  Each output changes in the same cycle as `state_code`.
- R9: `turn_left` and `turn_right` are never 1 in the same cycle.
- R10: `state_code` only ever holds 0 to 4. The three unused codes of the 3-bit register lead back to seek on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; feelers sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset to seek |
| feel_l | input | 1 | Left feeler contact, 1 = touching |
| feel_r | input | 1 | Right feeler contact, 1 = touching |
| step_fwd | output | 1 | Take a forward step |
| turn_left | output | 1 | Small counter-clockwise turn |
| turn_right | output | 1 | Small clockwise turn |
| state_code | output | 3 | Current state code (0 to 4) |

## Verification
The bench targets the cases where a left contact arrives together with a right contact in drift-right and in round. A design that gave the right-feeler arc priority would head to drift-left instead of pivot in those cases.

It also separates drift-right from round. Both drive the same outputs but react differently: a design that merged them, or that left drift-left on a lone right contact, would show the wrong code after the next edge.

Pivot is held with only one feeler touching, to catch a design that leaves pivot when the contact is not both-clear. Resets are injected mid-run, so a design that failed to drive the forward-only output pattern on re-entry to seek would be caught.

// File: rtl/maze_pkg.sv
package maze_pkg;

    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_SEEK    = 3'd0,
        ST_PIVOT   = 3'd1,
        ST_DRIFT_R = 3'd2,
        ST_DRIFT_L = 3'd3,
        ST_ROUND   = 3'd4
    } state_e;

    typedef struct packed {
        logic fwd;
        logic tl;
        logic tr;
    } act_t;

    typedef struct packed {
        state_e st;
        act_t   act;
    } regs_t;

endpackage

// File: rtl/maze_arc_select.sv
module maze_arc_select
    import maze_pkg::*;
(
    input  state_e cur_st,
    input  logic   feel_l,
    input  logic   feel_r,
    output state_e nxt_st
);
    logic any_touch;
    logic wall_mode;

    always_comb begin
        any_touch = feel_l | feel_r;
        wall_mode = (cur_st == ST_DRIFT_R) || (cur_st == ST_DRIFT_L)
                 || (cur_st == ST_ROUND);
        nxt_st    = ST_SEEK;
        if (wall_mode && feel_l) begin
            nxt_st = ST_PIVOT;
        end else begin
            case (cur_st)
                ST_SEEK:    nxt_st = any_touch ? ST_PIVOT : ST_SEEK;
                ST_PIVOT:   nxt_st = any_touch ? ST_PIVOT : ST_DRIFT_R;
                ST_DRIFT_R: nxt_st = feel_r ? ST_DRIFT_L : ST_DRIFT_R;
                ST_DRIFT_L: nxt_st = feel_r ? ST_DRIFT_L : ST_ROUND;
                ST_ROUND:   nxt_st = feel_r ? ST_DRIFT_L : ST_ROUND;
                default:    nxt_st = ST_SEEK;
            endcase
        end
    end
endmodule

// File: rtl/maze_act_decode.sv
module maze_act_decode
    import maze_pkg::*;
(
    input  state_e st,
    output act_t   act
);
    always_comb begin
        act = '0;
        case (st)
            ST_SEEK:    act = '{fwd: 1'b1, tl: 1'b0, tr: 1'b0};
            ST_PIVOT:   act = '{fwd: 1'b0, tl: 1'b1, tr: 1'b0};
            ST_DRIFT_R: act = '{fwd: 1'b1, tl: 1'b0, tr: 1'b1};
            ST_DRIFT_L: act = '{fwd: 1'b1, tl: 1'b1, tr: 1'b0};
            ST_ROUND:   act = '{fwd: 1'b1, tl: 1'b0, tr: 1'b1};
            default:    act = '0;
        endcase
    end
endmodule

// File: rtl/maze_follower.sv
module maze_follower
    import maze_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            feel_l,
    input  logic            feel_r,
    output logic            step_fwd,
    output logic            turn_left,
    output logic            turn_right,
    output logic [ST_W-1:0] state_code
);
    regs_t  r_d, r_q;
    state_e arc_st;
    state_e sel_st;
    act_t   sel_act;

    maze_arc_select u_arc (
        .cur_st (r_q.st),
        .feel_l (feel_l),
        .feel_r (feel_r),
        .nxt_st (arc_st)
    );

    // outputs are decoded from the next state and registered with it,
    // so they are a pure function of the registered state (Moore)
    maze_act_decode u_dec (
        .st  (sel_st),
        .act (sel_act)
    );

    always_comb begin
        sel_st   = rst ? ST_SEEK : arc_st;
        r_d      = r_q;
        r_d.st   = sel_st;
        r_d.act  = sel_act;
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign step_fwd   = r_q.act.fwd;
    assign turn_left  = r_q.act.tl;
    assign turn_right = r_q.act.tr;
    assign state_code = r_q.st;
endmodule

// File: rtl/maze_follower_chk.sv
module maze_follower_chk
    import maze_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            feel_l,
    input logic            feel_r,
    input logic            step_fwd,
    input logic            turn_left,
    input logic            turn_right,
    input logic [ST_W-1:0] state_code
);
    AST_RESET_SEEK: assert property (@(posedge clk)
        rst |=> (state_code == 3'd0) && step_fwd && !turn_left && !turn_right); // R1

    AST_SEEK_CONTACT: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd0) && (feel_l || feel_r) |=> state_code == 3'd1); // R2

    AST_PIVOT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1) && !feel_l && !feel_r |=> state_code == 3'd2); // R3

    AST_LEFT_BACKOFF: assert property (@(posedge clk) disable iff (rst)
        (state_code >= 3'd2) && (state_code <= 3'd4) && feel_l |=> state_code == 3'd1); // R7

    AST_PIVOT_OUTS: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd1) |-> !step_fwd && turn_left && !turn_right); // R8

    AST_TURN_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(turn_left && turn_right)); // R9

    AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        state_code <= 3'd4); // R10
endmodule

bind maze_follower maze_follower_chk u_chk (.*);

// File: tb/sim_maze_follower.sv
`timescale 1ns/1ps
module sim_maze_follower;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       feel_l = 1'b0;
    logic       feel_r = 1'b0;
    logic       step_fwd, turn_left, turn_right;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    logic [2:0] exp_st = 3'd0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    maze_follower u0 (
        .clk(clk), .rst(rst), .feel_l(feel_l), .feel_r(feel_r),
        .step_fwd(step_fwd), .turn_left(turn_left), .turn_right(turn_right),
        .state_code(state_code)
    );

    function automatic logic [2:0] mdl_next(logic [2:0] s, logic l, logic r);
        case (s)
            3'd0: return (l | r) ? 3'd1 : 3'd0;
            3'd1: return (l | r) ? 3'd1 : 3'd2;
            3'd2: return l ? 3'd1 : (r ? 3'd3 : 3'd2);
            3'd3: return l ? 3'd1 : (r ? 3'd3 : 3'd4);
            3'd4: return l ? 3'd1 : (r ? 3'd3 : 3'd4);
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [2:0] mdl_out(logic [2:0] s);
        case (s)
            3'd0: return 3'b100;
            3'd1: return 3'b010;
            3'd2: return 3'b101;
            3'd3: return 3'b110;
            3'd4: return 3'b101;
            default: return 3'b000;
        endcase
    endfunction

    function automatic string arc_tag(logic [2:0] s, logic l);
        if (s == 3'd0) return "R2";
        if (s == 3'd1) return "R3";
        if (l)         return "R7";
        if (s == 3'd2) return "R4";
        if (s == 3'd3) return "R5";
        return "R6";
    endfunction

    task automatic check_all(string tag);
        checks++;
        if (state_code !== exp_st) begin
            errors++;
            $display("FAIL %s state_code got %0d exp %0d", tag, state_code, exp_st);
        end
        checks++;
        if ({step_fwd, turn_left, turn_right} !== mdl_out(exp_st)) begin
            errors++;
            $display("FAIL R8 outputs got %b exp %b", {step_fwd, turn_left, turn_right},
                     mdl_out(exp_st));
        end
        checks++;
        if (turn_left && turn_right) begin
            errors++;
            $display("FAIL R9 turns got 11 exp not both");
        end
        checks++;
        if (state_code > 3'd4) begin
            errors++;
            $display("FAIL R10 state_code got %0d exp 0..4", state_code);
        end
    endtask

    // drive just after a falling edge, let one rising edge pass, check at the next falling edge
    task automatic step(logic l, logic r, logic rs);
        string tag;
        feel_l = l;
        feel_r = r;
        rst    = rs;
        tag    = rs ? "R1" : arc_tag(exp_st, l);
        @(posedge clk);
        exp_st = rs ? 3'd0 : mdl_next(exp_st, l, r);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got timeout exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4711);
        @(negedge clk);
        step(1'b1, 1'b1, 1'b1);           // R1 reset with contacts present
        step(1'b0, 1'b0, 1'b1);           // R1
        step(1'b0, 1'b0, 1'b0);           // R2 hold
        step(1'b0, 1'b1, 1'b0);           // R2 right contact -> pivot
        step(1'b1, 1'b1, 1'b0);           // R3 hold
        step(1'b1, 1'b0, 1'b0);           // R3 hold with left only
        step(1'b0, 1'b1, 1'b0);           // R3 hold with right only
        step(1'b0, 1'b0, 1'b0);           // R3 -> drift right
        step(1'b0, 1'b0, 1'b0);           // R4 hold
        step(1'b1, 1'b1, 1'b0);           // R7 both in drift right
        step(1'b0, 1'b0, 1'b0);           // R3
        step(1'b0, 1'b1, 1'b0);           // R4 -> drift left
        step(1'b0, 1'b1, 1'b0);           // R5 hold
        step(1'b0, 1'b0, 1'b0);           // R5 -> round
        step(1'b0, 1'b0, 1'b0);           // R6 hold
        step(1'b0, 1'b1, 1'b0);           // R6 -> drift left
        step(1'b0, 1'b0, 1'b0);           // R5 -> round
        step(1'b1, 1'b1, 1'b0);           // R7 both in round
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);           // R7 left in drift left
        step(1'b1, 1'b0, 1'b1);           // R1 reset from pivot
        step(1'b1, 1'b0, 1'b0);           // R2 left contact -> pivot
        for (int i = 0; i < 4000; i++) begin
            logic l, r, rs;
            l  = ($urandom % 4) == 0;
            r  = ($urandom % 2) == 0;
            rs = ($urandom % 250) == 0;
            step(l, r, rs);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule